// File: doc/BRIEF.md
# Base Address Window Decoder

This block decides which of a device's address windows are currently open on the bus and which window, if any, an incoming access falls into. A device has a configurable number of ordinary base registers plus one expansion-ROM register, which is always the highest-numbered region. For each region the block receives the raw register contents, a static window size (a power of two, or zero when the region does not exist) and a static space kind (I/O or memory). It also receives the two space-enable bits from the device's command register. From these it forms an effective base per region. That base is either the aligned window start or the all-ones value, which marks the region as unmapped.

Effective bases are not published straight away. A small scanning state machine visits one region per cycle in state SCAN_CHECK. It compares the freshly computed base with the base it currently holds. When the two differ, it moves to SCAN_UPDATE for one cycle. That cycle raises a one-cycle remap strobe carrying the region index, and the new base is stored at its end. The transitions are: SCAN_CHECK to SCAN_CHECK (no difference, advance to the next index), SCAN_CHECK to SCAN_UPDATE (difference found, index held), and SCAN_UPDATE to SCAN_CHECK (store and advance). The index wraps from the last region back to zero. Address decode always uses the held bases, so hits agree with the map the strobes have announced.

Top module: `bar_window_decoder`

## Requirements
- R1: After reset every region base reads all ones, no region is live, no hit is reported and the remap strobe is low.
- R2: A mapped region's base equals its register value ANDed with the complement of (size - 1). Region n's register is the n-th word of `bar_raw` (bits n*ADDR_W upward). The ROM register is the last word.
- R3: A region of size zero never becomes live, keeps an all-ones base and never produces a remap strobe or a hit.
- R4: An I/O region is unmapped while `cmd_io_en` is 0. A memory region, including the ROM region, is unmapped while `cmd_mem_en` is 0.
- R5: An I/O window is unmapped when its base is zero, when its last address (base + size - 1) is not above its base, or when its last address is 0x10000 or higher. A last address of exactly 0xFFFF is allowed.
- R6: A memory window is unmapped when its base is zero, when its last address wraps or is not above its base (so a size of 1 is never mapped), or when its last address is all ones.
- R7: The ROM region (highest index) is always treated as memory, whatever its `region_is_io` bit says. It is unmapped unless bit 0 of its register is 1.
- R8: The remap strobe lasts exactly one cycle and carries the region index on `remap_idx`. The published base of that region changes in the next cycle. A recomputation that yields the base already held produces no strobe.
- R9: `hit_vec` has at most one bit set. Bit n is set when region n is live, the access space (`acc_is_io`: 1 = I/O, 0 = memory) matches the region kind, and the address lies between base and base + size - 1 inclusive. When live windows overlap, the lowest index wins.
- R10: With inputs held steady, every region whose effective base changed has been strobed exactly once within 2*(NUM_BARS+1) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_io_en | input | 1 | Command register I/O space enable |
| cmd_mem_en | input | 1 | Command register memory space enable |
| bar_raw | input | (NUM_BARS+1)*ADDR_W (224) | Raw base registers, region 0 in the low word, ROM in the top word |
| region_size | input | (NUM_BARS+1)*ADDR_W (224) | Static window size per region, power of two or zero |
| region_is_io | input | NUM_BARS+1 (7) | Static space kind per region, 1 = I/O |
| acc_addr | input | ADDR_W (32) | Access address to decode |
| acc_is_io | input | 1 | Access space, 1 = I/O, 0 = memory |
| region_live | output | NUM_BARS+1 (7) | Region currently mapped |
| region_base | output | (NUM_BARS+1)*ADDR_W (224) | Published base per region, all ones when unmapped |
| hit_vec | output | NUM_BARS+1 (7) | One-hot window hit for the current access |
| remap_strobe | output | 1 | One-cycle pulse when a region's base changes |
| remap_idx | output | $clog2(NUM_BARS+1) (3) | Index of the region being remapped |

## Verification
The bound checker watches, on every cycle, that hits are one-hot and only on live regions, and that each strobe is a single cycle followed by a change of the published bases. It also checks that no published base changes without a strobe, and that every live window is aligned, non-zero and inside its space limit. Unused regions must stay inert. Only the bench's scenarios can show the exact base derived from a given register pattern, the gating by the two enable bits and the ROM enable bit, the exact boundary values 0xFFFF and all ones, the absence of a strobe on an identical rewrite, and the overlap priority.

// File: rtl/bar_dec_pkg.sv
package bar_dec_pkg;

    // Scanner states: compare one region, or commit a changed base.
    typedef enum logic [0:0] {
        SCAN_CHECK  = 1'b0,
        SCAN_UPDATE = 1'b1
    } scan_state_e;

endpackage

// File: rtl/bar_window_calc.sv
// Combinational effective-base computation for one region.
module bar_window_calc #(
    parameter int          ADDR_W  = 32,
    parameter bit          IS_ROM  = 1'b0,
    parameter int unsigned IO_SPAN = 65536
) (
    input  logic [ADDR_W-1:0] bar_val,
    input  logic [ADDR_W-1:0] win_size,
    input  logic              io_space,
    input  logic              io_enable,
    input  logic              mem_enable,
    output logic [ADDR_W-1:0] eff_base
);

    localparam logic [ADDR_W-1:0] UNMAPPED = '1;
    localparam logic [ADDR_W-1:0] ONE      = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] IO_TOP   = ADDR_W'(IO_SPAN);

    logic [ADDR_W-1:0] align_mask;
    logic [ADDR_W-1:0] cand_base;
    logic [ADDR_W-1:0] cand_last;
    logic              use_io;
    logic              space_on;
    logic              window_bad;

    always_comb begin
        align_mask = ~(win_size - ONE);
        cand_base  = bar_val & align_mask;
        cand_last  = cand_base + win_size - ONE;
        use_io     = io_space && !IS_ROM;
        if (use_io) begin
            space_on   = io_enable;
            window_bad = (cand_base == '0) || (cand_last <= cand_base) ||
                         (cand_last >= IO_TOP);
        end else begin
            space_on   = mem_enable && (!IS_ROM || bar_val[0]);
            window_bad = (cand_base == '0) || (cand_last <= cand_base) ||
                         (cand_last == UNMAPPED);
        end
        eff_base = ((win_size != '0) && space_on && !window_bad) ? cand_base : UNMAPPED;
    end

endmodule

// File: rtl/bar_scan_fsm.sv
// Round-robin scanner holding the published bases and issuing remap strobes.
module bar_scan_fsm
    import bar_dec_pkg::*;
#(
    parameter int NREG   = 7,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NREG*ADDR_W-1:0] fresh_bases,
    output logic [NREG*ADDR_W-1:0] held_bases,
    output logic                   remap_strobe,
    output logic [IDX_W-1:0]       remap_idx
);

    localparam logic [ADDR_W-1:0] UNMAPPED = '1;
    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(NREG - 1);

    logic [ADDR_W-1:0] fresh_arr [NREG];
    logic [ADDR_W-1:0] held_arr  [NREG];

    genvar g;
    generate
        for (g = 0; g < NREG; g++) begin : g_unpack
            assign fresh_arr[g]                   = fresh_bases[g*ADDR_W +: ADDR_W];
            assign held_bases[g*ADDR_W +: ADDR_W] = held_arr[g];
        end
    endgenerate

    scan_state_e       state_q, state_d;
    logic [IDX_W-1:0]  idx_q, idx_d, idx_next;
    logic [ADDR_W-1:0] pend_q;
    logic [ADDR_W-1:0] cand;
    logic [ADDR_W-1:0] cur;

    // Next-state logic
    always_comb begin
        cand     = fresh_arr[idx_q];
        cur      = held_arr[idx_q];
        idx_next = (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
        state_d  = state_q;
        idx_d    = idx_q;
        unique case (state_q)
            SCAN_CHECK: begin
                if (cand != cur) begin
                    state_d = SCAN_UPDATE;
                end else begin
                    idx_d = idx_next;
                end
            end
            SCAN_UPDATE: begin
                state_d = SCAN_CHECK;
                idx_d   = idx_next;
            end
            default: begin
                state_d = SCAN_CHECK;
                idx_d   = '0;
            end
        endcase
    end

    // State register, scan index and pending base
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SCAN_CHECK;
            idx_q   <= '0;
            pend_q  <= UNMAPPED;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            if (state_q == SCAN_CHECK) begin
                pend_q <= cand;
            end
        end
    end

    // Published base storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NREG; k++) begin
                held_arr[k] <= UNMAPPED;
            end
        end else if (state_q == SCAN_UPDATE) begin
            held_arr[idx_q] <= pend_q;
        end
    end

    // Outputs
    always_comb begin
        remap_strobe = (state_q == SCAN_UPDATE);
        remap_idx    = (state_q == SCAN_UPDATE) ? idx_q : '0;
    end

endmodule

// File: rtl/bar_hit_decode.sv
// Window hit decode against the published bases, lowest index wins.
module bar_hit_decode #(
    parameter int NREG    = 7,
    parameter int ADDR_W  = 32,
    parameter int ROM_IDX = 6
) (
    input  logic [NREG*ADDR_W-1:0] held_bases,
    input  logic [NREG*ADDR_W-1:0] win_sizes,
    input  logic [NREG-1:0]        region_io,
    input  logic [ADDR_W-1:0]      acc_addr,
    input  logic                   acc_io,
    output logic [NREG-1:0]        live,
    output logic [NREG-1:0]        hit
);

    localparam logic [ADDR_W-1:0] UNMAPPED = '1;
    localparam logic [ADDR_W-1:0] ONE      = ADDR_W'(1);

    logic [NREG-1:0] raw_hit;

    genvar g;
    generate
        for (g = 0; g < NREG; g++) begin : g_region
            localparam bit ROM_SLOT = (g == ROM_IDX);
            logic [ADDR_W-1:0] b;
            logic [ADDR_W-1:0] s;
            logic              kind_io;
            assign b          = held_bases[g*ADDR_W +: ADDR_W];
            assign s          = win_sizes[g*ADDR_W +: ADDR_W];
            assign kind_io    = ROM_SLOT ? 1'b0 : region_io[g];
            assign live[g]    = (b != UNMAPPED) && (s != '0);
            assign raw_hit[g] = live[g] && (acc_io == kind_io) &&
                                ((acc_addr & ~(s - ONE)) == b);
        end
    endgenerate

    logic taken;
    always_comb begin
        taken = 1'b0;
        for (int k = 0; k < NREG; k++) begin
            hit[k] = raw_hit[k] && !taken;
            taken  = taken | raw_hit[k];
        end
    end

endmodule

// File: rtl/bar_window_decoder.sv
module bar_window_decoder
    import bar_dec_pkg::*;
#(
    parameter int          NUM_BARS = 6,
    parameter int          ADDR_W   = 32,
    parameter int unsigned IO_SPAN  = 65536,
    localparam int         NREG     = NUM_BARS + 1,
    localparam int         IDX_W    = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_io_en,
    input  logic                   cmd_mem_en,
    input  logic [NREG*ADDR_W-1:0] bar_raw,
    input  logic [NREG*ADDR_W-1:0] region_size,
    input  logic [NREG-1:0]        region_is_io,
    input  logic [ADDR_W-1:0]      acc_addr,
    input  logic                   acc_is_io,
    output logic [NREG-1:0]        region_live,
    output logic [NREG*ADDR_W-1:0] region_base,
    output logic [NREG-1:0]        hit_vec,
    output logic                   remap_strobe,
    output logic [IDX_W-1:0]       remap_idx
);

    localparam int ROM_IDX = NREG - 1;

    logic [NREG*ADDR_W-1:0] fresh_bases;

    genvar g;
    generate
        for (g = 0; g < NREG; g++) begin : g_calc
            bar_window_calc #(
                .ADDR_W  (ADDR_W),
                .IS_ROM  (g == ROM_IDX),
                .IO_SPAN (IO_SPAN)
            ) calc_i (
                .bar_val    (bar_raw[g*ADDR_W +: ADDR_W]),
                .win_size   (region_size[g*ADDR_W +: ADDR_W]),
                .io_space   (region_is_io[g]),
                .io_enable  (cmd_io_en),
                .mem_enable (cmd_mem_en),
                .eff_base   (fresh_bases[g*ADDR_W +: ADDR_W])
            );
        end
    endgenerate

    bar_scan_fsm #(
        .NREG   (NREG),
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W)
    ) scan_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .fresh_bases  (fresh_bases),
        .held_bases   (region_base),
        .remap_strobe (remap_strobe),
        .remap_idx    (remap_idx)
    );

    bar_hit_decode #(
        .NREG    (NREG),
        .ADDR_W  (ADDR_W),
        .ROM_IDX (ROM_IDX)
    ) hit_i (
        .held_bases (region_base),
        .win_sizes  (region_size),
        .region_io  (region_is_io),
        .acc_addr   (acc_addr),
        .acc_io     (acc_is_io),
        .live       (region_live),
        .hit        (hit_vec)
    );

endmodule

// File: rtl/bar_window_decoder_chk.sv
module bar_window_decoder_chk #(
    parameter int          NUM_BARS = 6,
    parameter int          ADDR_W   = 32,
    parameter int unsigned IO_SPAN  = 65536,
    localparam int         NREG     = NUM_BARS + 1,
    localparam int         IDX_W    = (NREG > 1) ? $clog2(NREG) : 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NREG*ADDR_W-1:0] region_size,
    input logic [NREG-1:0]        region_is_io,
    input logic [NREG-1:0]        region_live,
    input logic [NREG*ADDR_W-1:0] region_base,
    input logic [NREG-1:0]        hit_vec,
    input logic                   remap_strobe,
    input logic [IDX_W-1:0]       remap_idx
);

    localparam logic [ADDR_W-1:0] UNMAPPED = '1;
    localparam logic [ADDR_W-1:0] ONE      = ADDR_W'(1);
    localparam int                ROM_IDX  = NREG - 1;

    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        remap_strobe |=> !remap_strobe);

    assert_strobe_moves_base_R8: assert property (@(posedge clk) disable iff (!rst_n)
        remap_strobe |=> (region_base != $past(region_base)));

    assert_base_needs_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (region_base != $past(region_base)) |-> $past(remap_strobe));

    assert_strobe_idx_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        remap_strobe |-> (int'(remap_idx) <= ROM_IDX));

    assert_hit_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    assert_hit_needs_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_vec & ~region_live) == '0);

    genvar g;
    generate
        for (g = 0; g < NREG; g++) begin : g_reg
            logic [ADDR_W-1:0] b;
            logic [ADDR_W-1:0] s;
            assign b = region_base[g*ADDR_W +: ADDR_W];
            assign s = region_size[g*ADDR_W +: ADDR_W];

            assert_unused_inert_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (s == '0) |-> ((b == UNMAPPED) && !region_live[g] && !hit_vec[g]));

            assert_aligned_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
                region_live[g] |-> (((b & (s - ONE)) == '0) && (b != '0)));

            if (g != ROM_IDX) begin : g_io
                assert_io_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
                    (region_live[g] && region_is_io[g]) |->
                    ((64'(b) + 64'(s)) <= 64'(IO_SPAN)));
            end

            assert_mem_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (region_live[g] && ((g == ROM_IDX) || !region_is_io[g])) |->
                ((64'(b) + 64'(s)) < (64'(1) << ADDR_W)));
        end
    endgenerate

endmodule

bind bar_window_decoder bar_window_decoder_chk #(
    .NUM_BARS (NUM_BARS),
    .ADDR_W   (ADDR_W),
    .IO_SPAN  (IO_SPAN)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .region_size  (region_size),
    .region_is_io (region_is_io),
    .region_live  (region_live),
    .region_base  (region_base),
    .hit_vec      (hit_vec),
    .remap_strobe (remap_strobe),
    .remap_idx    (remap_idx)
);

// File: tb/bar_window_decoder_tb_top.sv
module bar_window_decoder_tb_top;

    localparam int NUM_BARS = 6;
    localparam int ADDR_W   = 32;
    localparam int NREG     = NUM_BARS + 1;
    localparam int IDX_W    = 3;
    localparam int ROM      = NREG - 1;
    localparam int SETTLE   = 2 * NREG + 2;
    localparam logic [31:0] ONES = 32'hFFFF_FFFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic                   cmd_io_en = 1'b0;
    logic                   cmd_mem_en = 1'b0;
    logic [31:0]            bar_v  [NREG];
    logic [31:0]            size_v [NREG];
    logic [NREG-1:0]        kind_io;
    logic [NREG*32-1:0]     bar_raw;
    logic [NREG*32-1:0]     size_flat;
    logic [31:0]            acc_addr = '0;
    logic                   acc_is_io = 1'b0;
    logic [NREG-1:0]        region_live;
    logic [NREG*32-1:0]     region_base;
    logic [NREG-1:0]        hit_vec;
    logic                   remap_strobe;
    logic [IDX_W-1:0]       remap_idx;

    always_comb begin
        for (int k = 0; k < NREG; k++) begin
            bar_raw[k*32 +: 32]   = bar_v[k];
            size_flat[k*32 +: 32] = size_v[k];
        end
    end

    bar_window_decoder #(.NUM_BARS(NUM_BARS), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_io_en(cmd_io_en), .cmd_mem_en(cmd_mem_en),
        .bar_raw(bar_raw), .region_size(size_flat), .region_is_io(kind_io),
        .acc_addr(acc_addr), .acc_is_io(acc_is_io), .region_live(region_live),
        .region_base(region_base), .hit_vec(hit_vec), .remap_strobe(remap_strobe),
        .remap_idx(remap_idx)
    );

    int checks = 0;
    int fails  = 0;
    bit running = 1'b0;
    bit finished = 1'b0;
    bit collecting = 1'b0;
    logic [NREG-1:0] seen_mask;
    int seen_dup;
    int col_cyc;
    int last_cyc;
    logic [NREG*32-1:0] prev_base;

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rb(int k);
        return region_base[k*32 +: 32];
    endfunction

    // Reference effective base from the requirements
    function automatic logic [31:0] exp_base(int k);
        longint unsigned sz, b, last;
        bit io;
        sz = size_v[k];
        io = (k == ROM) ? 1'b0 : kind_io[k];
        if (sz == 0) return ONES;
        b    = longint'(bar_v[k]) & ~(sz - 1) & 64'hFFFF_FFFF;
        last = b + sz - 1;
        if (io) begin
            if (!cmd_io_en) return ONES;
            if (b == 0 || sz == 1 || last >= 64'h1_0000) return ONES;
        end else begin
            if (!cmd_mem_en) return ONES;
            if (k == ROM && !bar_v[k][0]) return ONES;
            if (b == 0 || sz == 1 || last >= 64'hFFFF_FFFF) return ONES;
        end
        return b[31:0];
    endfunction

    // Per-clock reference of live/hit from published bases
    logic [NREG-1:0] mon_live, mon_hit;
    logic [63:0]     mon_b, mon_s;
    bit              mon_taken, mon_match;
    always @(negedge clk) begin
        if (collecting) begin
            col_cyc++;
            if (remap_strobe) begin
                if (seen_mask[remap_idx]) seen_dup++;
                seen_mask[remap_idx] = 1'b1;
                last_cyc = col_cyc;
            end
        end
        if (running) begin
            mon_taken = 1'b0;
            for (int k = 0; k < NREG; k++) begin
                mon_b = 64'(region_base[k*32 +: 32]);
                mon_s = 64'(size_v[k]);
                mon_live[k] = (mon_b != 64'(ONES)) && (mon_s != 0);
                mon_match = (k == ROM) ? !acc_is_io : (acc_is_io == kind_io[k]);
                mon_hit[k] = mon_live[k] && mon_match && !mon_taken &&
                             (64'(acc_addr) >= mon_b) && (64'(acc_addr) <= mon_b + mon_s - 1);
                if (mon_hit[k]) mon_taken = 1'b1;
            end
            chk("R9", "live per clock", 64'(region_live), 64'(mon_live));
            chk("R9", "hit per clock", 64'(hit_vec), 64'(mon_hit));
        end
    end

    task automatic drive_point();
        @(posedge clk);
        #1;
    endtask

    // Called at a drive point right after inputs change
    task automatic settle(string req);
        logic [NREG-1:0] want_mask;
        prev_base  = region_base;
        seen_mask  = '0;
        seen_dup   = 0;
        col_cyc    = 0;
        last_cyc   = 0;
        collecting = 1'b1;
        repeat (SETTLE) @(negedge clk);
        collecting = 1'b0;
        for (int k = 0; k < NREG; k++) begin
            want_mask[k] = (exp_base(k) != prev_base[k*32 +: 32]);
            chk(req, $sformatf("base of region %0d", k), 64'(rb(k)), 64'(exp_base(k)));
        end
        chk("R8", "strobed region set", 64'(seen_mask), 64'(want_mask));
        chk("R8", "duplicate strobes", 64'(seen_dup), 64'd0);
        chk("R10", "strobes within sweep bound", 64'(last_cyc <= 2 * NREG), 64'd1);
        drive_point();
    endtask

    task automatic probe(string req, logic [31:0] a, logic io, logic [NREG-1:0] want);
        acc_addr  = a;
        acc_is_io = io;
        @(negedge clk);
        chk(req, $sformatf("hit for %h io=%0d", a, io), 64'(hit_vec), 64'(want));
        drive_point();
    endtask

    initial begin
        for (int k = 0; k < NREG; k++) bar_v[k] = '0;
        size_v[0] = 32'h20;   size_v[1] = 32'h1000; size_v[2] = 32'h0;
        size_v[3] = 32'h100;  size_v[4] = 32'h10;   size_v[5] = 32'h1;
        size_v[6] = 32'h800;
        kind_io = 7'b100_1001;   // regions 0 and 3 I/O; ROM bit set but ignored

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "bases after reset", 64'(region_base == {NREG*32{1'b1}}), 64'd1);
        chk("R1", "live after reset", 64'(region_live), 64'd0);
        chk("R1", "hit after reset", 64'(hit_vec), 64'd0);
        chk("R1", "strobe after reset", 64'(remap_strobe), 64'd0);
        running = 1'b1;
        drive_point();

        // Main mapping
        cmd_io_en = 1'b1; cmd_mem_en = 1'b1;
        bar_v[0] = 32'h0000_C021; bar_v[1] = 32'h8000_1008; bar_v[2] = 32'h1234_0000;
        bar_v[3] = 32'h0000_1200; bar_v[4] = 32'h9000_0004; bar_v[5] = 32'hA000_0000;
        bar_v[6] = 32'hC000_0801;
        settle("R2");
        chk("R2", "region 0 aligned base", 64'(rb(0)), 64'h0000_C020);
        chk("R2", "region 1 aligned base", 64'(rb(1)), 64'h8000_1000);
        chk("R3", "unused region", 64'(rb(2)), 64'(ONES));
        chk("R6", "size one memory region", 64'(rb(5)), 64'(ONES));
        chk("R7", "ROM enabled", 64'(rb(6)), 64'hC000_0800);
        probe("R9", 32'h0000_C020, 1'b1, 7'b000_0001);
        probe("R9", 32'h0000_C03F, 1'b1, 7'b000_0001);
        probe("R9", 32'h0000_C040, 1'b1, 7'b000_0000);
        probe("R9", 32'h0000_C020, 1'b0, 7'b000_0000);
        probe("R9", 32'h8000_1FFF, 1'b0, 7'b000_0010);
        probe("R7", 32'hC000_0FFF, 1'b0, 7'b100_0000);
        probe("R7", 32'hC000_0FFF, 1'b1, 7'b000_0000);
        probe("R3", 32'h1234_0000, 1'b0, 7'b000_0000);

        // I/O enable off
        cmd_io_en = 1'b0;
        settle("R4");
        chk("R4", "I/O region 0 off", 64'(rb(0)), 64'(ONES));
        chk("R4", "memory region 1 kept", 64'(rb(1)), 64'h8000_1000);
        probe("R4", 32'h0000_C020, 1'b1, 7'b000_0000);

        // I/O limits
        cmd_io_en = 1'b1; bar_v[0] = 32'h0000_0001; bar_v[3] = 32'h0000_FF00;
        settle("R5");
        chk("R5", "zero I/O base", 64'(rb(0)), 64'(ONES));
        chk("R5", "I/O ending at 0xFFFF", 64'(rb(3)), 64'h0000_FF00);
        probe("R5", 32'h0000_FFFF, 1'b1, 7'b000_1000);
        bar_v[3] = 32'h0001_0000;
        settle("R5");
        chk("R5", "I/O past limit", 64'(rb(3)), 64'(ONES));

        // Memory limits
        bar_v[1] = 32'hFFFF_F000; bar_v[4] = 32'hFFFF_FFE0;
        settle("R6");
        chk("R6", "memory ending at all ones", 64'(rb(1)), 64'(ONES));
        chk("R6", "memory ending below all ones", 64'(rb(4)), 64'hFFFF_FFE0);
        probe("R6", 32'hFFFF_FFEF, 1'b0, 7'b001_0000);

        // ROM enable bit and memory enable
        bar_v[6] = 32'hC000_0800;
        settle("R7");
        chk("R7", "ROM enable bit clear", 64'(rb(6)), 64'(ONES));
        bar_v[6] = 32'hC000_0801;
        settle("R7");
        cmd_mem_en = 1'b0;
        settle("R4");
        chk("R4", "memory off: live only I/O", 64'(region_live), 64'd0);

        // Identical rewrite
        cmd_mem_en = 1'b1;
        settle("R8");
        bar_v[6] = 32'hC000_0801; bar_v[4] = 32'hFFFF_FFE0;
        settle("R8");
        chk("R8", "no strobe on identical rewrite", 64'(seen_mask), 64'd0);

        // Overlap priority
        bar_v[1] = 32'h9000_0000; bar_v[4] = 32'h9000_0000;
        settle("R2");
        probe("R9", 32'h9000_0000, 1'b0, 7'b000_0010);
        probe("R9", 32'h9000_0010, 1'b0, 7'b000_0010);

        running = 1'b0;
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule